// File: doc/BRIEF.md
# Serial Engine DMA Channel Controller

This block moves one buffer between system memory and one serial engine, in one direction that a parameter selects. Software sets a 64-bit start address as two 32-bit halves and an attribute word, then writes the byte count. Writing the byte count starts the transfer. In the transmit build the channel reads bytes from memory and passes them to the engine. In the receive build it takes bytes from the engine and writes them to memory. Both builds use a byte-wide request/grant port to reach memory.

Three events are tracked as sticky status bits: normal completion, end-of-transfer and bus error. Each event has an interrupt enable. The enables can be written whole, set bit by bit, or cleared bit by bit, so software never needs a read-modify-write. The receive build also accepts a flush command that stops a transfer part way through. A readback register gives the number of bytes actually moved.

Top module: `sedma_channel`

## Requirements
- R1: After a synchronous reset, status, enables and moved count read zero, `irq` is low and `mem_req` is low.
- R2: `irq` is high exactly when some status bit and its enable are both set, and it follows status with no extra cycle. The bit map is: bit 0 done, bit 1 end-of-transfer, bit 2 bus error.
- R3: Register index 4 writes the enables whole. Index 5 sets the enables where the data has ones. Index 6 clears the enables where the data has ones. Index 4 reads the enables back.
- R4: Index 0 holds the low address half and index 1 holds the high half. Bytes are moved at consecutive ascending addresses starting at that 64-bit address.
- R5: On transmit, attribute bit 0 (index 2) set makes a finished transfer raise end-of-transfer along with done. On receive, the attribute is ignored and reads zero.
- R6: A write of N to index 3 starts a transfer of N bytes. Index 8 reports the bytes moved, and index 7 bit 8 reads as busy.
- R7: Status bits at index 7 are write-one-to-clear. Writing zeros leaves them unchanged.
- R8: A write to index 3 while busy is ignored. Both the running transfer and the length readback keep their values.
- R9: A length of zero completes at once with done set and makes no memory request.
- R10: A grant with `mem_err` aborts the transfer and sets the bus-error bit without done. The moved count holds the bytes granted before the error.
- R11: On receive, engine bytes are written to memory in arrival order.
- R12: On receive, writing 1 to index 9 stops a running transfer, sets end-of-transfer without done, and clears busy. On transmit, that write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe, data valid next cycle |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write (receive build) |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | One-cycle grant completing the request |
| mem_err | input | 1 | Error response, valid with grant |
| mem_rdata | input | 8 | Read byte, valid with grant |
| eng_in_valid | input | 1 | Engine byte available (receive) |
| eng_in_ready | output | 1 | Channel takes an engine byte (receive) |
| eng_in_data | input | 8 | Engine byte (receive) |
| eng_out_valid | output | 1 | One-cycle strobe of a byte to the engine (transmit) |
| eng_out_data | output | 8 | Byte to the engine (transmit) |

## Verification
Directed transfers with fixed lengths, grant latencies and addresses check byte order, the 64-bit address, and how end-of-transfer differs between attribute settings. Separate cases cover the edges: zero length, a length write while busy, an error grant in mid-buffer, a receive flush while the engine source is stalled, and a transmit flush. Each of these cases tells the abort paths apart from normal completion. Randomized transmit runs use random start addresses, random lengths and random grant latency of zero to three cycles. They show that the byte count and data order do not depend on memory timing.

// File: rtl/sedma_pkg.sv
`timescale 1ns/1ps
package sedma_pkg;
  typedef enum logic [1:0] {XS_IDLE, XS_FILL, XS_BUS} xfer_state_e;

  typedef struct packed {
    logic err;
    logic eot;
    logic done;
  } ev_t;

  localparam logic [3:0] RI_PTR_LO = 4'd0;
  localparam logic [3:0] RI_PTR_HI = 4'd1;
  localparam logic [3:0] RI_ATTR   = 4'd2;
  localparam logic [3:0] RI_LEN    = 4'd3;
  localparam logic [3:0] RI_EN     = 4'd4;
  localparam logic [3:0] RI_EN_SET = 4'd5;
  localparam logic [3:0] RI_EN_CLR = 4'd6;
  localparam logic [3:0] RI_STATUS = 4'd7;
  localparam logic [3:0] RI_MOVED  = 4'd8;
  localparam logic [3:0] RI_FLUSH  = 4'd9;

  localparam int NUM_EV   = 3;
  localparam int BUSY_BIT = 8;
endpackage

// File: rtl/sedma_regs.sv
`timescale 1ns/1ps
module sedma_regs import sedma_pkg::*; #(
  parameter int IS_RX = 0,
  parameter int LEN_W = 16,
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [3:0]         cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  output logic               irq,
  input  logic               busy,
  input  logic [LEN_W-1:0]   xfer_count,
  input  ev_t                ev,
  output logic               start,
  output logic [2*REG_W-1:0] buf_ptr,
  output logic               attr_eot,
  output logic               flush
);
  logic [REG_W-1:0]  ptr_lo_q, ptr_hi_q, rd_mux;
  logic              attr_q;
  logic [LEN_W-1:0]  len_q;
  logic [NUM_EV-1:0] en_q, en_d, st_q, st_d, wbits;

  assign wbits    = cfg_wdata[NUM_EV-1:0];
  assign start    = cfg_we && (cfg_addr == RI_LEN) && !busy;
  assign flush    = (IS_RX != 0) && cfg_we && (cfg_addr == RI_FLUSH) && cfg_wdata[0];
  assign buf_ptr  = {ptr_hi_q, ptr_lo_q};
  assign attr_eot = attr_q;

  always_comb begin
    en_d = en_q;
    if (cfg_we) begin
      case (cfg_addr)
        RI_EN:     en_d = wbits;
        RI_EN_SET: en_d = en_q | wbits;
        RI_EN_CLR: en_d = en_q & ~wbits;
        default:   en_d = en_q;
      endcase
    end
  end

  always_comb begin
    st_d = st_q;
    if (cfg_we && cfg_addr == RI_STATUS) st_d = st_q & ~wbits;
    st_d = st_d | ev;
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_addr)
      RI_PTR_LO: rd_mux = ptr_lo_q;
      RI_PTR_HI: rd_mux = ptr_hi_q;
      RI_ATTR:   rd_mux = REG_W'(attr_q);
      RI_LEN:    rd_mux = REG_W'(len_q);
      RI_EN, RI_EN_SET, RI_EN_CLR: rd_mux = REG_W'(en_q);
      RI_STATUS: rd_mux = REG_W'({busy, {(BUSY_BIT-NUM_EV){1'b0}}, st_q});
      RI_MOVED:  rd_mux = REG_W'(xfer_count);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_lo_q  <= '0;
      ptr_hi_q  <= '0;
      attr_q    <= 1'b0;
      len_q     <= '0;
      en_q      <= '0;
      st_q      <= '0;
      irq       <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we && cfg_addr == RI_PTR_LO) ptr_lo_q <= cfg_wdata;
      if (cfg_we && cfg_addr == RI_PTR_HI) ptr_hi_q <= cfg_wdata;
      if (cfg_we && cfg_addr == RI_ATTR)   attr_q   <= (IS_RX == 0) ? cfg_wdata[0] : 1'b0;
      if (start) len_q <= cfg_wdata[LEN_W-1:0];
      en_q <= en_d;
      st_q <= st_d;
      irq  <= |(st_d & en_d);
      if (cfg_re) cfg_rdata <= rd_mux;
    end
  end

  // R8
  len_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == RI_LEN && busy) |=> $stable(len_q));
  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == RI_EN_SET) |=> ((en_q & $past(wbits)) == $past(wbits)));
  // R10
  err_status_chk: assert property (@(posedge clk) disable iff (rst)
    ev.err |=> st_q[2]);
endmodule

// File: rtl/sedma_xfer.sv
`timescale 1ns/1ps
module sedma_xfer import sedma_pkg::*; #(
  parameter int IS_RX  = 0,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [ADDR_W-1:0] base,
  input  logic              attr_eot,
  input  logic              flush,
  output logic              busy,
  output logic [LEN_W-1:0]  count,
  output ev_t               ev,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              eng_in_valid,
  output logic              eng_in_ready,
  input  logic [BYTE_W-1:0] eng_in_data,
  output logic              eng_out_valid,
  output logic [BYTE_W-1:0] eng_out_data
);
  localparam xfer_state_e FIRST_ST = (IS_RX != 0) ? XS_FILL : XS_BUS;

  xfer_state_e       st_q;
  logic [LEN_W-1:0]  tgt_q, cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wbuf_q;
  logic              eot_q, last;

  assign last         = (cnt_q + LEN_W'(1)) == tgt_q;
  assign busy         = st_q != XS_IDLE;
  assign count        = cnt_q;
  assign mem_req      = st_q == XS_BUS;
  assign mem_we       = IS_RX != 0;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wbuf_q;
  assign eng_in_ready = st_q == XS_FILL;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= XS_IDLE;
      tgt_q         <= '0;
      cnt_q         <= '0;
      addr_q        <= '0;
      wbuf_q        <= '0;
      eot_q         <= 1'b0;
      ev            <= '0;
      eng_out_valid <= 1'b0;
      eng_out_data  <= '0;
    end else begin
      ev            <= '0;
      eng_out_valid <= 1'b0;
      case (st_q)
        XS_IDLE: if (start) begin
          cnt_q  <= '0;
          tgt_q  <= start_len;
          addr_q <= base;
          eot_q  <= attr_eot && (IS_RX == 0);
          if (start_len == '0) begin
            ev.done <= 1'b1;
            ev.eot  <= attr_eot && (IS_RX == 0);
          end else begin
            st_q <= FIRST_ST;
          end
        end
        XS_FILL: if (flush) begin
          st_q   <= XS_IDLE;
          ev.eot <= 1'b1;
        end else if (eng_in_valid) begin
          wbuf_q <= eng_in_data;
          st_q   <= XS_BUS;
        end
        XS_BUS: if (flush) begin
          st_q   <= XS_IDLE;
          ev.eot <= 1'b1;
        end else if (mem_gnt) begin
          if (mem_err) begin
            st_q   <= XS_IDLE;
            ev.err <= 1'b1;
          end else begin
            cnt_q  <= cnt_q + LEN_W'(1);
            addr_q <= addr_q + ADDR_W'(1);
            if (IS_RX == 0) begin
              eng_out_valid <= 1'b1;
              eng_out_data  <= mem_rdata;
            end
            if (last) begin
              st_q    <= XS_IDLE;
              ev.done <= 1'b1;
              ev.eot  <= eot_q;
            end else begin
              st_q <= FIRST_ST;
            end
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  // R6
  cnt_le_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q < tgt_q));
  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({ev.done, ev.err}) <= 1);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> $stable(mem_addr));
  // R10
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && mem_err && !flush) |=> !busy);
endmodule

// File: rtl/sedma_channel.sv
`timescale 1ns/1ps
module sedma_channel import sedma_pkg::*; #(
  parameter int IS_RX = 0,
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic        cfg_re,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_err,
  input  logic [7:0]  mem_rdata,
  input  logic        eng_in_valid,
  output logic        eng_in_ready,
  input  logic [7:0]  eng_in_data,
  output logic        eng_out_valid,
  output logic [7:0]  eng_out_data
);
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2 * REG_W;

  logic              start, attr_eot, flush, busy;
  logic [ADDR_W-1:0] buf_ptr;
  logic [LEN_W-1:0]  count;
  ev_t               ev;

  sedma_regs #(.IS_RX(IS_RX), .LEN_W(LEN_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq(irq), .busy(busy), .xfer_count(count), .ev(ev),
    .start(start), .buf_ptr(buf_ptr), .attr_eot(attr_eot), .flush(flush)
  );

  sedma_xfer #(.IS_RX(IS_RX), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .BYTE_W(8)) u_xfer (
    .clk(clk), .rst(rst), .start(start), .start_len(cfg_wdata[LEN_W-1:0]),
    .base(buf_ptr), .attr_eot(attr_eot), .flush(flush),
    .busy(busy), .count(count), .ev(ev),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .eng_in_valid(eng_in_valid),
    .eng_in_ready(eng_in_ready), .eng_in_data(eng_in_data),
    .eng_out_valid(eng_out_valid), .eng_out_data(eng_out_data)
  );
endmodule

// File: tb/sedma_channel_tb.sv
`timescale 1ns/1ps
module sedma_channel_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // TX instance signals
  logic        t_we = 0, t_re = 0;
  logic [3:0]  t_addr = 0;
  logic [31:0] t_wdata = 0, t_rdata;
  logic        t_irq, t_req, t_mwe, t_gnt, t_err, t_in_ready, t_out_valid, t_dummy_v;
  logic [63:0] t_maddr;
  logic [7:0]  t_mwdata, t_mrdata, t_out_data;
  // RX instance signals
  logic        r_we = 0, r_re = 0;
  logic [3:0]  r_addr = 0;
  logic [31:0] r_wdata = 0, r_rdata;
  logic        r_irq, r_req, r_mwe, r_gnt, r_err, r_in_valid, r_in_ready, r_out_valid;
  logic [63:0] r_maddr;
  logic [7:0]  r_mwdata, r_mrdata, r_in_data, r_out_data;

  assign t_dummy_v = 1'b0;

  sedma_channel #(.IS_RX(0), .LEN_W(16)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(t_we), .cfg_re(t_re), .cfg_addr(t_addr),
    .cfg_wdata(t_wdata), .cfg_rdata(t_rdata), .irq(t_irq),
    .mem_req(t_req), .mem_we(t_mwe), .mem_addr(t_maddr), .mem_wdata(t_mwdata),
    .mem_gnt(t_gnt), .mem_err(t_err), .mem_rdata(t_mrdata),
    .eng_in_valid(t_dummy_v), .eng_in_ready(t_in_ready), .eng_in_data(8'h00),
    .eng_out_valid(t_out_valid), .eng_out_data(t_out_data));

  sedma_channel #(.IS_RX(1), .LEN_W(16)) u_dut_rx (
    .clk(clk), .rst(rst), .cfg_we(r_we), .cfg_re(r_re), .cfg_addr(r_addr),
    .cfg_wdata(r_wdata), .cfg_rdata(r_rdata), .irq(r_irq),
    .mem_req(r_req), .mem_we(r_mwe), .mem_addr(r_maddr), .mem_wdata(r_mwdata),
    .mem_gnt(r_gnt), .mem_err(r_err), .mem_rdata(r_mrdata),
    .eng_in_valid(r_in_valid), .eng_in_ready(r_in_ready), .eng_in_data(r_in_data),
    .eng_out_valid(r_out_valid), .eng_out_data(r_out_data));

  // Memory and stimulus controls (written only by the initial block)
  logic [7:0]  mem_tx [0:255];
  logic [7:0]  mem_rx [0:255];
  logic        err_en = 1'b0;
  logic [63:0] err_addr = '0;
  logic [31:0] exp_hi = 32'h0;
  int          rx_allow = 0;

  // Responder and monitor state (written only by always blocks)
  logic [1:0]  t_wait, r_wait;
  int          g_tx = 0, tx_n = 0, rx_sent = 0;
  logic [7:0]  tx_log [0:255];
  logic        hi_bad = 1'b0;

  function automatic logic [7:0] tx_pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      t_gnt <= 0; t_err <= 0; t_wait <= 0; t_mrdata <= 0;
    end else if (t_gnt) begin
      t_gnt <= 0; t_err <= 0;
    end else if (t_req) begin
      if (t_maddr[63:32] != exp_hi) hi_bad <= 1'b1;
      if (t_wait != 0) t_wait <= t_wait - 1;
      else begin
        t_gnt    <= 1;
        t_mrdata <= mem_tx[t_maddr[7:0]];
        t_err    <= err_en && (t_maddr == err_addr);
        t_wait   <= 2'($urandom % 4);
        g_tx     <= g_tx + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      r_gnt <= 0; r_err <= 0; r_wait <= 0; r_mrdata <= 0;
    end else if (r_gnt) begin
      r_gnt <= 0; r_err <= 0;
    end else if (r_req) begin
      if (r_wait != 0) r_wait <= r_wait - 1;
      else begin
        r_gnt  <= 1;
        r_wait <= 2'($urandom % 4);
        if (r_mwe) mem_rx[r_maddr[7:0]] <= r_mwdata;
      end
    end
  end

  always @(posedge clk) begin
    if (t_out_valid) begin
      tx_log[tx_n[7:0]] <= t_out_data;
      tx_n <= tx_n + 1;
    end
  end

  assign r_in_valid = rx_sent < rx_allow;
  assign r_in_data  = 8'(rx_sent + 8'h40);
  always @(posedge clk) if (r_in_valid && r_in_ready) rx_sent <= rx_sent + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit rx, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    if (rx) begin r_we = 1; r_addr = a; r_wdata = d; end
    else    begin t_we = 1; t_addr = a; t_wdata = d; end
    @(negedge clk);
    r_we = 0; t_we = 0;
  endtask

  task automatic rd(input bit rx, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    if (rx) begin r_re = 1; r_addr = a; end
    else    begin t_re = 1; t_addr = a; end
    @(negedge clk);
    d = rx ? r_rdata : t_rdata;
    r_re = 0; t_re = 0;
  endtask

  task automatic wait_idle(input bit rx, input string tag);
    logic [31:0] s;
    for (int k = 0; k < 600; k++) begin
      rd(rx, 4'd7, s);
      if (!s[8]) return;
    end
    chk({tag, " idle timeout"}, 1, 0);
  endtask

  initial begin
    logic [31:0] v;
    int n0, bad, len, base, g0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin mem_tx[i] = tx_pat(i); mem_rx[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(0, 4'd7, v); chk("R1 status", v, 0);
    rd(0, 4'd4, v); chk("R1 enables", v, 0);
    rd(0, 4'd8, v); chk("R1 moved", v, 0);
    chk("R1 irq/req", {t_irq, t_req}, 0);

    // R3 enable aliases
    wr(0, 4'd4, 32'h2); rd(0, 4'd4, v); chk("R3 plain", v, 2);
    wr(0, 4'd5, 32'h5); rd(0, 4'd4, v); chk("R3 set", v, 7);
    wr(0, 4'd6, 32'h3); rd(0, 4'd4, v); chk("R3 clear", v, 4);

    // R4 R5 R6 transmit with end-of-transfer mark
    exp_hi = 32'h0000_0001;
    wr(0, 4'd0, 32'h10); wr(0, 4'd1, exp_hi); wr(0, 4'd2, 1);
    wr(0, 4'd4, 7);
    n0 = tx_n;
    wr(0, 4'd3, 5);
    wait_idle(0, "R6");
    bad = 0;
    for (int i = 0; i < 5; i++) if (tx_log[8'(n0 + i)] !== tx_pat(16 + i)) bad++;
    chk("R4 byte order", bad, 0);
    chk("R4 high address half", hi_bad, 0);
    rd(0, 4'd8, v); chk("R6 moved", v, 5);
    rd(0, 4'd7, v); chk("R5 done+eot", v, 3);
    chk("R2 irq enabled", t_irq, 1);

    // R2 R7 masking and W1C
    wr(0, 4'd4, 0); chk("R2 irq masked", t_irq, 0);
    wr(0, 4'd5, 2); chk("R2 irq eot only", t_irq, 1);
    wr(0, 4'd7, 0); rd(0, 4'd7, v); chk("R7 zero write keeps", v, 3);
    wr(0, 4'd7, 2); rd(0, 4'd7, v); chk("R7 clear eot", v, 1);
    chk("R2 irq after clear", t_irq, 0);
    wr(0, 4'd7, 1); rd(0, 4'd7, v); chk("R7 clear done", v, 0);

    // R5 without mark
    wr(0, 4'd2, 0); wr(0, 4'd3, 4); wait_idle(0, "R5");
    rd(0, 4'd7, v); chk("R5 done only", v, 1);
    wr(0, 4'd7, 7);

    // R8 length write while busy
    wr(0, 4'd3, 6); wr(0, 4'd3, 2); wait_idle(0, "R8");
    rd(0, 4'd8, v); chk("R8 moved", v, 6);
    rd(0, 4'd3, v); chk("R8 length kept", v, 6);
    wr(0, 4'd7, 7);

    // R9 zero length
    g0 = g_tx;
    wr(0, 4'd3, 0); repeat (4) @(negedge clk);
    rd(0, 4'd7, v); chk("R9 done at once", v, 1);
    rd(0, 4'd8, v); chk("R9 moved", v, 0);
    chk("R9 no request", g_tx - g0, 0);
    wr(0, 4'd7, 7);

    // R10 bus error
    wr(0, 4'd0, 32'h40);
    err_addr = {exp_hi, 32'h43}; err_en = 1'b1;
    wr(0, 4'd3, 8); wait_idle(0, "R10");
    rd(0, 4'd7, v); chk("R10 error status", v, 4);
    rd(0, 4'd8, v); chk("R10 moved before error", v, 3);
    err_en = 1'b0;
    wr(0, 4'd7, 7);

    // R12 flush has no effect on transmit
    wr(0, 4'd3, 4); wr(0, 4'd9, 1); wait_idle(0, "R12 tx");
    rd(0, 4'd8, v); chk("R12 tx flush ignored", v, 4);
    rd(0, 4'd7, v); chk("R12 tx done", v, 1);
    wr(0, 4'd7, 7);

    // R5 receive attribute ignored
    wr(1, 4'd2, 1); rd(1, 4'd2, v); chk("R5 rx attr zero", v, 0);

    // R11 receive transfer
    wr(1, 4'd0, 32'h80); wr(1, 4'd1, 0);
    rx_allow = rx_sent + 6;
    n0 = rx_sent;
    wr(1, 4'd3, 6); wait_idle(1, "R11");
    bad = 0;
    for (int i = 0; i < 6; i++) if (mem_rx[8'h80 + i] !== 8'(n0 + i + 8'h40)) bad++;
    chk("R11 rx bytes", bad, 0);
    rd(1, 4'd8, v); chk("R11 rx moved", v, 6);
    rd(1, 4'd7, v); chk("R11 rx done", v, 1);
    wr(1, 4'd7, 7);

    // R12 receive flush with stalled source
    rx_allow = rx_sent + 3;
    wr(1, 4'd3, 10);
    repeat (40) @(negedge clk);
    rd(1, 4'd7, v); chk("R12 rx busy before flush", v[8], 1);
    wr(1, 4'd9, 1);
    repeat (2) @(negedge clk);
    rd(1, 4'd7, v); chk("R12 rx flushed status", v, 2);
    rd(1, 4'd8, v); chk("R12 rx moved", v, 3);

    // R4 R6 random transmit runs
    for (int r = 0; r < 20; r++) begin
      base = int'($urandom % 256);
      len  = 1 + int'($urandom % 20);
      wr(0, 4'd0, 32'(base));
      n0 = tx_n;
      wr(0, 4'd3, 32'(len)); wait_idle(0, "R6 rand");
      bad = 0;
      for (int i = 0; i < len; i++) if (tx_log[8'(n0 + i)] !== tx_pat((base + i) % 256)) bad++;
      chk("R4 random bytes", bad, 0);
      rd(0, 4'd8, v); chk("R6 random moved", v, 32'(len));
      wr(0, 4'd7, 7);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule